// File: doc/BRIEF.md
# Multi-Sprite Priority Compositor

This block overlays a parameterised set of 32×32 sprites (4 to 32 of them, 8 by default) on a background pixel stream for an 800×600 raster clocked at 40 MHz. A timing source upstream supplies the current column and row, an active-area flag, both sync levels and the background colour for each pixel. The block returns the composed RGB444 colour together with the sync levels, all delayed by the same fixed number of clocks so the display path stays aligned.

The attributes of every sprite sit in a small register-based table: a column, a row, a pattern select and an enable bit. A host writes one entry per clock through a plain address/data/write-enable port. For each pixel, every sprite's box is tested in parallel. The sprite-local offset drives a procedural pattern generator with one clock of latency. A priority encoder then picks the lowest-numbered sprite whose returned colour is not the transparent key.

Top module: `spr_compositor`

## Requirements
- R1: While `rst_n` is low, `out_rgb`, `out_hsync` and `out_vsync` are zero and every table entry reads as disabled.
- R2: `out_rgb`, `out_hsync` and `out_vsync` after clock edge k reflect the inputs sampled at edge k-2, which is a fixed latency of three registers.
- R3: When `in_active` was low for a pixel, that pixel's `out_rgb` is 12'h000.
- R4: When no enabled sprite gives a non-zero colour at an active pixel, `out_rgb` equals that pixel's `bg_rgb`.
- R5: A sprite at (x, y) covers columns x to x+31 and rows y to y+31. Its local offset is u = column − x and w = row − y.
- R6: Pattern 0 is a disc. If (u−16)²+(w−16)² ≤ 196 the colour is {u[4:1], w[4:1], 4'hA}, otherwise 12'h000. Pattern 1 is a diamond. If |u−16|+|w−16| < 16 the colour is {4'h5, u[3:0], w[3:0]}, otherwise 12'h000.
- R7: A sprite colour of 12'h000 is transparent, and the next sprite down or the background shows instead.
- R8: Among covering sprites with non-zero colour, the lowest index wins.
- R9: A sprite whose enable bit is 0 has no effect on the output.
- R10: Coverage uses the full sum, so a box reaching past column 2047 or row 2047 does not wrap to low coordinates. A box past the right or bottom edge of the active area is clipped.
- R11: A table write sets entry `attr_addr` from `attr_wdata`, with x in bits [10:0], y in [21:11], pattern select in [22] and enable in [23]. The new entry applies to pixels presented from the next clock edge onward. Addresses at or above the sprite count are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| attr_we | input | 1 | Table write strobe |
| attr_addr | input | $clog2(N_SPR) | Sprite index to write |
| attr_wdata | input | 24 | Entry {en, pat, y[10:0], x[10:0]} |
| in_h | input | 11 | Current column |
| in_v | input | 11 | Current row |
| in_active | input | 1 | Pixel lies in the visible area |
| in_hsync | input | 1 | Horizontal sync level |
| in_vsync | input | 1 | Vertical sync level |
| bg_rgb | input | 12 | Background colour for this pixel |
| out_rgb | output | 12 | Composed RGB444 colour |
| out_hsync | output | 1 | Horizontal sync, delayed |
| out_vsync | output | 1 | Vertical sync, delayed |

## Verification
A stale or corrupted table entry shows on the very next pixel that the sprite covers, as a wrong colour or a missing sprite three clocks later. A misaligned stage shows as an edge of a sprite or background shifted by one column at the box boundaries. A faulty winner selection appears only where boxes overlap with opaque pixels, so the stimulus stacks three sprites with differing transparent corners. It also places boxes at the far edges of the coordinate space, where a narrow compare would wrap.

// File: rtl/spr_pkg.sv
package spr_pkg;
  localparam int COORD_W = 11;
  localparam int RGB_W   = 12;
  localparam int SPR_DIM = 32;
  localparam int SPR_LW  = $clog2(SPR_DIM);

  typedef struct packed {
    logic               en;
    logic               pat;
    logic [COORD_W-1:0] y;
    logic [COORD_W-1:0] x;
  } spr_attr_t;

  localparam int ATTR_W = $bits(spr_attr_t);
endpackage

// File: rtl/spr_attr_table.sv
module spr_attr_table
  import spr_pkg::*;
#(
  parameter int N_SPR = 8,
  localparam int AW = $clog2(N_SPR)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we_i,
  input  logic [AW-1:0]         addr_i,
  input  spr_attr_t             wdata_i,
  output spr_attr_t [N_SPR-1:0] attr_o
);
  spr_attr_t [N_SPR-1:0] tab_q, tab_d;
  logic                  wr_ok;

  assign wr_ok = we_i && (int'(addr_i) < N_SPR);

  always_comb begin
    tab_d = tab_q;
    if (wr_ok) tab_d[addr_i] = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tab_q <= '0;
    else if (wr_ok) tab_q <= tab_d;
  end

  assign attr_o = tab_q;

  p_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> attr_o[$past(addr_i)] == $past(wdata_i));
endmodule

// File: rtl/spr_pattern.sv
module spr_pattern
  import spr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_i,
  input  logic              pat_i,
  input  logic [SPR_LW-1:0] u_i,
  input  logic [SPR_LW-1:0] w_i,
  output logic [RGB_W-1:0]  pix_o
);
  localparam int CTR  = SPR_DIM / 2;
  localparam int RAD2 = (CTR - 2) * (CTR - 2);

  logic [SPR_LW:0]   du, dw;
  logic [2*SPR_LW+1:0] d2;
  logic              in_disc, in_diam;
  logic [RGB_W-1:0]  disc_c, diam_c, pix_d;

  always_comb begin
    du = (int'(u_i) >= CTR) ? (SPR_LW+1)'(int'(u_i) - CTR) : (SPR_LW+1)'(CTR - int'(u_i));
    dw = (int'(w_i) >= CTR) ? (SPR_LW+1)'(int'(w_i) - CTR) : (SPR_LW+1)'(CTR - int'(w_i));
    d2 = ((2*SPR_LW+2)'(du) * (2*SPR_LW+2)'(du)) + ((2*SPR_LW+2)'(dw) * (2*SPR_LW+2)'(dw));
    in_disc = int'(d2) <= RAD2;
    in_diam = (int'(du) + int'(dw)) < CTR;
    disc_c  = {u_i[SPR_LW-1:SPR_LW-4], w_i[SPR_LW-1:SPR_LW-4], 4'hA};
    diam_c  = {4'h5, u_i[3:0], w_i[3:0]};
    pix_d   = '0;
    if (hit_i) begin
      if (pat_i) pix_d = in_diam ? diam_c : '0;
      else       pix_d = in_disc ? disc_c : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pix_o <= '0;
    else        pix_o <= pix_d;
  end

  p_nohit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_i |=> pix_o == '0);
endmodule

// File: rtl/spr_prio_enc.sv
module spr_prio_enc
  import spr_pkg::*;
#(
  parameter int N_SPR = 8
) (
  input  logic [N_SPR-1:0][RGB_W-1:0] pix_i,
  output logic [N_SPR-1:0]            grant_o,
  output logic                        valid_o,
  output logic [RGB_W-1:0]            rgb_o
);
  always_comb begin
    grant_o = '0;
    valid_o = 1'b0;
    rgb_o   = '0;
    for (int i = N_SPR - 1; i >= 0; i--) begin
      if (pix_i[i] != '0) begin
        grant_o = '0;
        grant_o[i] = 1'b1;
        valid_o = 1'b1;
        rgb_o   = pix_i[i];
      end
    end
  end
endmodule

// File: rtl/spr_compositor.sv
module spr_compositor
  import spr_pkg::*;
#(
  parameter int N_SPR = 8,
  localparam int AW = $clog2(N_SPR)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               attr_we,
  input  logic [AW-1:0]      attr_addr,
  input  logic [ATTR_W-1:0]  attr_wdata,
  input  logic [COORD_W-1:0] in_h,
  input  logic [COORD_W-1:0] in_v,
  input  logic               in_active,
  input  logic               in_hsync,
  input  logic               in_vsync,
  input  logic [RGB_W-1:0]   bg_rgb,
  output logic [RGB_W-1:0]   out_rgb,
  output logic               out_hsync,
  output logic               out_vsync
);
  spr_attr_t [N_SPR-1:0] attr;

  spr_attr_table #(.N_SPR(N_SPR)) u_tab (
    .clk(clk), .rst_n(rst_n), .we_i(attr_we), .addr_i(attr_addr),
    .wdata_i(spr_attr_t'(attr_wdata)), .attr_o(attr)
  );

  // stage 0: box test and local offset per sprite
  logic [N_SPR-1:0]             hit_d, hit_s0, pat_s0;
  logic [N_SPR-1:0][SPR_LW-1:0] u_d, w_d, u_s0, w_s0;
  logic [N_SPR-1:0][RGB_W-1:0]  pix_s1;

  for (genvar g = 0; g < N_SPR; g++) begin : g_spr
    logic [COORD_W:0]   h_x, v_x, x_lo, y_lo, x_hi, y_hi;
    logic [COORD_W-1:0] du, dw;
    always_comb begin
      h_x  = {1'b0, in_h};
      v_x  = {1'b0, in_v};
      x_lo = {1'b0, attr[g].x};
      y_lo = {1'b0, attr[g].y};
      x_hi = x_lo + (COORD_W+1)'(SPR_DIM);
      y_hi = y_lo + (COORD_W+1)'(SPR_DIM);
      du   = in_h - attr[g].x;
      dw   = in_v - attr[g].y;
      hit_d[g] = attr[g].en && (h_x >= x_lo) && (h_x < x_hi)
                            && (v_x >= y_lo) && (v_x < y_hi);
      u_d[g] = du[SPR_LW-1:0];
      w_d[g] = dw[SPR_LW-1:0];
    end

    spr_pattern u_pat (
      .clk(clk), .rst_n(rst_n), .hit_i(hit_s0[g]), .pat_i(pat_s0[g]),
      .u_i(u_s0[g]), .w_i(w_s0[g]), .pix_o(pix_s1[g])
    );
  end

  logic             act_s0, hs_s0, vs_s0, act_s1, hs_s1, vs_s1;
  logic [RGB_W-1:0] bg_s0, bg_s1;
  logic [N_SPR-1:0] pat_d;

  always_comb begin
    for (int i = 0; i < N_SPR; i++) pat_d[i] = attr[i].pat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_s0 <= '0; pat_s0 <= '0; u_s0 <= '0; w_s0 <= '0;
      act_s0 <= 1'b0; hs_s0 <= 1'b0; vs_s0 <= 1'b0; bg_s0 <= '0;
      act_s1 <= 1'b0; hs_s1 <= 1'b0; vs_s1 <= 1'b0; bg_s1 <= '0;
    end else begin
      hit_s0 <= hit_d; pat_s0 <= pat_d; u_s0 <= u_d; w_s0 <= w_d;
      act_s0 <= in_active; hs_s0 <= in_hsync; vs_s0 <= in_vsync; bg_s0 <= bg_rgb;
      act_s1 <= act_s0; hs_s1 <= hs_s0; vs_s1 <= vs_s0; bg_s1 <= bg_s0;
    end
  end

  // stage 2: winner selection and output register
  logic [N_SPR-1:0] grant;
  logic             win_vld;
  logic [RGB_W-1:0] win_rgb, rgb_d;

  spr_prio_enc #(.N_SPR(N_SPR)) u_enc (
    .pix_i(pix_s1), .grant_o(grant), .valid_o(win_vld), .rgb_o(win_rgb)
  );

  always_comb begin
    rgb_d = '0;
    if (act_s1) rgb_d = win_vld ? win_rgb : bg_s1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_rgb <= '0; out_hsync <= 1'b0; out_vsync <= 1'b0;
    end else begin
      out_rgb <= rgb_d; out_hsync <= hs_s1; out_vsync <= vs_s1;
    end
  end

  p_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !act_s1 |=> out_rgb == '0);
  p_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_s1 != out_hsync) |=> out_hsync == $past(hs_s1));
  p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (win_vld == (grant != '0)));
  p_opaque_r7: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld |-> win_rgb != '0);
endmodule

// File: tb/sim_spr_compositor.sv
`timescale 1ns/1ps
module sim_spr_compositor;
  localparam int N = 8;
  localparam int AW = $clog2(N);

  logic clk = 1'b0, rst_n = 1'b0;
  logic attr_we = 1'b0;
  logic [AW-1:0] attr_addr = '0;
  logic [23:0] attr_wdata = '0;
  logic [10:0] in_h = '0, in_v = '0;
  logic in_active = 1'b0, in_hsync = 1'b0, in_vsync = 1'b0;
  logic [11:0] bg_rgb = '0;
  logic [11:0] out_rgb;
  logic out_hsync, out_vsync;

  always #2 clk = ~clk;

  spr_compositor #(.N_SPR(N)) u0 (.*);

  int total = 0, bad = 0;
  bit done = 0;
  string tag = "R1";

  int mx[N], my[N];
  bit mp[N], me[N];
  int exp_rgb[3], exp_hs[3], exp_vs[3];
  string exp_tag[3];
  int vld = 0;

  function automatic int pat_col(bit p, int u, int w);
    int du = (u >= 16) ? u - 16 : 16 - u;
    int dw = (w >= 16) ? w - 16 : 16 - w;
    if (!p) return (du*du + dw*dw <= 196) ? ((u/2)*256 + (w/2)*16 + 10) : 0;
    return (du + dw < 16) ? (5*256 + (u%16)*16 + (w%16)) : 0;
  endfunction

  function automatic int model(int h, int v, bit act, int bg);
    int res = bg;
    for (int i = N-1; i >= 0; i--) begin
      if (me[i] && h >= mx[i] && h < mx[i]+32 && v >= my[i] && v < my[i]+32) begin
        int c = pat_col(mp[i], h - mx[i], v - my[i]);
        if (c != 0) res = c;
      end
    end
    return act ? res : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld = 0;
      for (int i = 0; i < N; i++) begin mx[i] = 0; my[i] = 0; mp[i] = 0; me[i] = 0; end
    end else begin
      for (int k = 2; k > 0; k--) begin
        exp_rgb[k] = exp_rgb[k-1]; exp_hs[k] = exp_hs[k-1];
        exp_vs[k] = exp_vs[k-1]; exp_tag[k] = exp_tag[k-1];
      end
      exp_rgb[0] = model(in_h, in_v, in_active, bg_rgb);
      exp_hs[0] = in_hsync; exp_vs[0] = in_vsync; exp_tag[0] = tag;
      if (attr_we && attr_addr < N) begin
        mx[attr_addr] = attr_wdata[10:0]; my[attr_addr] = attr_wdata[21:11];
        mp[attr_addr] = attr_wdata[22];   me[attr_addr] = attr_wdata[23];
      end
      if (vld < 3) vld++;
    end
  end

  task automatic check(string t, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%03h expected=%03h", t, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      check("R1 rgb in reset", out_rgb, 0);
      check("R1 sync in reset", {out_hsync, out_vsync}, 0);
    end else if (vld >= 3) begin
      check(exp_tag[2], out_rgb, exp_rgb[2]);
      check("R2 sync delay", {out_hsync, out_vsync}, {exp_hs[2][0], exp_vs[2][0]});
    end
  end

  task automatic px(int h, int v, bit we, int a, logic [23:0] d);
    @(negedge clk);
    in_h = h; in_v = v;
    in_active = (h < 800) && (v < 600);
    in_hsync = (h >= 840) && (h < 968);
    in_vsync = (v >= 601) && (v < 605);
    bg_rgb = 12'((h*7 + v*13) % 4096);
    attr_we = we; attr_addr = AW'(a); attr_wdata = d;
  endtask

  function automatic logic [23:0] ent(int x, int y, bit p, bit e);
    return {e, p, 11'(y), 11'(x)};
  endfunction

  task automatic wr(int a, logic [23:0] d);
    px(1000, 620, 1'b1, a, d);
    px(1000, 620, 1'b0, 0, '0);
  endtask

  task automatic sweep(string t, int v0, int v1, int h0, int h1);
    tag = t;
    for (int v = v0; v <= v1; v++)
      for (int h = h0; h <= h1; h++) px(h, v, 1'b0, 0, '0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(4*200000);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R4 R1: empty table after reset, background passes, blanking zero (R3)
    sweep("R4 R3 R1 empty table", 598, 602, 780, 1055);
    // populate table
    wr(0, ent(100, 100, 0, 1));
    wr(1, ent(110, 110, 1, 1));
    wr(6, ent(105, 105, 1, 1));
    wr(2, ent(784, 584, 0, 1));
    wr(3, ent(2040, 2040, 1, 1));
    wr(4, ent(300, 300, 0, 0));
    wr(5, ent(1020, 40, 1, 1));
    sweep("R5 R6 R7 R8 overlap stack", 98, 145, 90, 160);
    sweep("R10 R3 clip right bottom", 580, 602, 770, 830);
    sweep("R10 wrap corner", 0, 3, 0, 40);
    sweep("R9 disabled sprite", 298, 333, 296, 334);
    sweep("R3 R5 sprite in blanking", 38, 42, 1010, 1055);
    // R11: mid-line rewrite takes effect on the next pixel
    tag = "R11 write timing";
    for (int h = 190; h <= 260; h++)
      px(h, 210, h == 215, 7, ent(200, 195, 1, 1));
    for (int h = 190; h <= 260; h++)
      px(h, 211, h == 230, 7, ent(200, 195, 0, 1));
    // R11 out-of-range address is not writable with a power-of-two count; R9 disable top sprite
    wr(0, ent(100, 100, 0, 0));
    sweep("R9 R11 top sprite disabled", 98, 145, 90, 160);
    wr(1, ent(2047, 100, 1, 1));
    sweep("R10 R8 x near limit", 98, 130, 0, 40);
    repeat (4) px(1000, 620, 1'b0, 0, '0);
    finish_run();
  end
endmodule